// File: doc/BRIEF.md
# Load-Store Ordering Violation Checker

This block watches memory operations that execute out of program order and decides what each executing load must do. Stores that have executed are kept in a store queue, and loads that have executed are kept in a load queue. Each entry holds its doubleword address, a byte mask and an age tag. When a load executes, the block searches the store queue for stores that are older than the load and overlap it. The youngest such store decides the outcome: the load takes its data from that store, is sent back for reissue, or forces a flush. If no older store overlaps, the load reads the cache.

When a store executes, it searches the load queue for younger loads that have already executed and touched any of its bytes. Those loads read stale data, so the block asks for a flush that starts at the oldest of them. Any flush removes every queue entry whose age is equal to or younger than the flush age. Store data can arrive together with the store address or later on a separate data port. Retire pulses remove committed entries by age.

Top module: `lsq_order_guard`

## Requirements
- R1: After reset both queues are empty and `ldDone`, `ldReject` and `flushReq` are low, so the first load is sent to the cache.
- R2: A load with no older overlapping store in the queue gets `ldSource` 0 (cache), reported with `ldDone` one cycle after `ldValid`, and is recorded in the load queue.
- R3: Sizes are coded 0, 1, 2, 3 for 1, 2, 4, 8 bytes, always naturally aligned within a doubleword. Store data enters in the low lanes. If the youngest older overlapping store has its data and covers every byte of the load, `ldSource` is 1 (forward) and `ldData` holds the load's bytes in the low lanes with upper bytes zero.
- R4: When several older stores overlap a load, only the youngest of them decides the outcome and supplies data.
- R5: If the youngest older overlapping store has no data yet, `ldSource` is 2 (reject), `ldReject` is high, no flush is requested and the load is not recorded.
- R6: If the youngest older overlapping store has data but does not cover every load byte, `ldSource` is 3 (flush) and `flushReq` is raised with `flushAge` equal to the load's age.
- R7: An executing store that overlaps one or more younger executed loads raises `flushReq` one cycle later with `flushAge` equal to the oldest of those loads; otherwise no flush is raised and `ldDone` stays low.
- R8: A flush removes every store and load entry whose age equals or is younger than the flush age, so a purged load cannot trigger a later ordering flush.
- R9: Age tags carry one wrap bit; tag A is older than tag B when (A - B) modulo 2^AGE_W has its top bit set, so ordering holds across the wrap from the largest tag to zero.
- R10: A store that executed without data gains it through the store data port, matched by age, after which loads it covers are forwarded.
- R11: A retire pulse removes the entry with the given age; a retired store no longer forwards to or rejects later loads.
- R12: Stores younger than a load are ignored by that load's search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | A load executes this cycle |
| ldAddr | input | ADDR_W | Load byte address |
| ldSize | input | 2 | Load size code |
| ldAge | input | AGE_W | Load age tag |
| stValid | input | 1 | A store executes this cycle |
| stAddr | input | ADDR_W | Store byte address |
| stSize | input | 2 | Store size code |
| stAge | input | AGE_W | Store age tag |
| stHasData | input | 1 | Store data is supplied with the address |
| stData | input | 64 | Store data, low lanes |
| sdValid | input | 1 | Late store data arrives |
| sdAge | input | AGE_W | Age of the store receiving late data |
| sdData | input | 64 | Late store data, low lanes |
| stRetValid | input | 1 | Retire a store entry |
| stRetAge | input | AGE_W | Age of the retiring store |
| ldRetValid | input | 1 | Retire a load entry |
| ldRetAge | input | AGE_W | Age of the retiring load |
| ldDone | output | 1 | Load outcome valid |
| ldSource | output | 2 | Load outcome: 0 cache, 1 forward, 2 reject, 3 flush |
| ldData | output | 64 | Forwarded load data, low lanes |
| ldReject | output | 1 | Load must be reissued |
| flushReq | output | 1 | Flush request |
| flushAge | output | AGE_W | Age from which everything is discarded |

## Verification
Every outcome of this block is due exactly one cycle after the execute pulse that caused it: the load result, the reject flag and a flush caused by either a load or a store. The queues are updated on that same edge, so a purge or retire is visible to the next operation. The bench drives each operation on a falling edge, holds it across one rising edge, and samples all outputs on the following falling edge, with only one operation in flight so that each result maps to exactly one stimulus.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [1:0] {
    SRC_CACHE  = 2'd0,
    SRC_FWD    = 2'd1,
    SRC_REJECT = 2'd2,
    SRC_FLUSH  = 2'd3
  } ldSrc_e;

  typedef struct packed {
    logic ldWrite;
    logic stWrite;
    logic flushEn;
  } ctlStrobe_t;

  function automatic logic [7:0] byteMask(logic [2:0] off, logic [1:0] sz);
    logic [7:0] base;
    case (sz)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      2'd2:    base = 8'h0F;
      default: base = 8'hFF;
    endcase
    return base << off;
  endfunction

  function automatic logic [63:0] laneBits(logic [7:0] m);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

endpackage

// File: rtl/lsq_datapath.sv
module lsq_datapath
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AGE_W  = 5,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [AGE_W-1:0]  flushAge,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [1:0]        ldSize,
  input  logic [AGE_W-1:0]  ldAge,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic [AGE_W-1:0]  stAge,
  input  logic              stHasData,
  input  logic [63:0]       stData,
  input  logic              sdValid,
  input  logic [AGE_W-1:0]  sdAge,
  input  logic [63:0]       sdData,
  input  logic              stRetValid,
  input  logic [AGE_W-1:0]  stRetAge,
  input  logic              ldRetValid,
  input  logic [AGE_W-1:0]  ldRetAge,
  output logic              ldHit,
  output logic              ldHitData,
  output logic              ldContained,
  output logic [63:0]       ldFwdData,
  output logic              stViol,
  output logic [AGE_W-1:0]  stViolAge
);

  localparam int IDX_W  = $clog2(DEPTH);
  localparam int LINE_W = ADDR_W - 3;

  function automatic logic isOlder(logic [AGE_W-1:0] a, logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction

  logic              sqValid [DEPTH];
  logic              sqDataOk[DEPTH];
  logic [LINE_W-1:0] sqLine  [DEPTH];
  logic [7:0]        sqMask  [DEPTH];
  logic [2:0]        sqOff   [DEPTH];
  logic [AGE_W-1:0]  sqAge   [DEPTH];
  logic [63:0]       sqWord  [DEPTH];
  logic              lqValid [DEPTH];
  logic [LINE_W-1:0] lqLine  [DEPTH];
  logic [7:0]        lqMask  [DEPTH];
  logic [AGE_W-1:0]  lqAge   [DEPTH];

  logic [LINE_W-1:0] ldLine, stLine;
  logic [7:0]        ldMask, stMask;
  logic [IDX_W-1:0]  sqFree, lqFree, best;
  logic [AGE_W-1:0]  bestAge;

  assign ldLine = ldAddr[ADDR_W-1:3];
  assign stLine = stAddr[ADDR_W-1:3];
  assign ldMask = byteMask(ldAddr[2:0], ldSize);
  assign stMask = byteMask(stAddr[2:0], stSize);

  always_comb begin
    sqFree = '0;
    lqFree = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!sqValid[i]) sqFree = IDX_W'(i);
      if (!lqValid[i]) lqFree = IDX_W'(i);
    end
  end

  // load search: youngest older store that overlaps
  always_comb begin
    ldHit   = 1'b0;
    best    = '0;
    bestAge = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sqValid[i] && sqLine[i] == ldLine && |(sqMask[i] & ldMask) &&
          isOlder(sqAge[i], ldAge) && (!ldHit || isOlder(bestAge, sqAge[i]))) begin
        ldHit   = 1'b1;
        best    = IDX_W'(i);
        bestAge = sqAge[i];
      end
    end
  end

  assign ldHitData   = sqDataOk[best];
  assign ldContained = (ldMask & ~sqMask[best]) == 8'h00;
  assign ldFwdData   = (sqWord[best] >> {ldAddr[2:0], 3'b000}) &
                       laneBits(byteMask(3'd0, ldSize));

  // store search: oldest younger executed load that overlaps
  always_comb begin
    stViol    = 1'b0;
    stViolAge = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lqValid[i] && lqLine[i] == stLine && |(lqMask[i] & stMask) &&
          isOlder(stAge, lqAge[i]) && (!stViol || isOlder(lqAge[i], stViolAge))) begin
        stViol    = 1'b1;
        stViolAge = lqAge[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) begin
        sqValid[i]  <= 1'b0;
        sqDataOk[i] <= 1'b0;
        sqLine[i]   <= '0;
        sqMask[i]   <= '0;
        sqOff[i]    <= '0;
        sqAge[i]    <= '0;
        sqWord[i]   <= '0;
        lqValid[i]  <= 1'b0;
        lqLine[i]   <= '0;
        lqMask[i]   <= '0;
        lqAge[i]    <= '0;
      end else begin
        if (stRetValid && sqValid[i] && sqAge[i] == stRetAge) sqValid[i] <= 1'b0;
        if (ldRetValid && lqValid[i] && lqAge[i] == ldRetAge) lqValid[i] <= 1'b0;
        if (strobe.flushEn && !isOlder(sqAge[i], flushAge)) sqValid[i] <= 1'b0;
        if (strobe.flushEn && !isOlder(lqAge[i], flushAge)) lqValid[i] <= 1'b0;
        if (sdValid && sqValid[i] && sqAge[i] == sdAge) begin
          sqDataOk[i] <= 1'b1;
          sqWord[i]   <= sdData << {sqOff[i], 3'b000};
        end
        if (strobe.stWrite && sqFree == IDX_W'(i)) begin
          sqValid[i]  <= 1'b1;
          sqDataOk[i] <= stHasData;
          sqLine[i]   <= stLine;
          sqMask[i]   <= stMask;
          sqOff[i]    <= stAddr[2:0];
          sqAge[i]    <= stAge;
          sqWord[i]   <= stData << {stAddr[2:0], 3'b000};
        end
        if (strobe.ldWrite && lqFree == IDX_W'(i)) begin
          lqValid[i] <= 1'b1;
          lqLine[i]  <= ldLine;
          lqMask[i]  <= ldMask;
          lqAge[i]   <= ldAge;
        end
      end
    end
  end

  logic flushSeen;
  assign flushSeen = strobe.flushEn;

  for (genvar g = 0; g < DEPTH; g++) begin : g_purge
    // R8
    sq_purge_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(flushSeen) && sqValid[g] |-> isOlder(sqAge[g], $past(flushAge)));
    // R8
    lq_purge_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(flushSeen) && lqValid[g] |-> isOlder(lqAge[g], $past(flushAge)));
  end

endmodule

// File: rtl/lsq_control.sv
module lsq_control
  import lsq_pkg::*;
#(
  parameter int AGE_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ldValid,
  input  logic [AGE_W-1:0] ldAge,
  input  logic             stValid,
  input  logic [AGE_W-1:0] stAge,
  input  logic             ldHit,
  input  logic             ldHitData,
  input  logic             ldContained,
  input  logic [63:0]      ldFwdData,
  input  logic             stViol,
  input  logic [AGE_W-1:0] stViolAge,
  output ctlStrobe_t       strobe,
  output logic [AGE_W-1:0] flushAge,
  output logic             ldDone,
  output ldSrc_e           ldSource,
  output logic [63:0]      ldData,
  output logic             ldReject,
  output logic             flushReq,
  output logic [AGE_W-1:0] flushReqAge
);

  function automatic logic isOlder(logic [AGE_W-1:0] a, logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction

  ldSrc_e outcome;
  logic   ldFlush, stFlush;

  always_comb begin
    if (!ldHit)           outcome = SRC_CACHE;
    else if (!ldHitData)  outcome = SRC_REJECT;
    else if (ldContained) outcome = SRC_FWD;
    else                  outcome = SRC_FLUSH;
  end

  assign ldFlush = ldValid && outcome == SRC_FLUSH;
  assign stFlush = stValid && stViol;

  always_comb begin
    if (ldFlush && stFlush) flushAge = isOlder(ldAge, stViolAge) ? ldAge : stViolAge;
    else if (ldFlush)       flushAge = ldAge;
    else                    flushAge = stViolAge;
    strobe.flushEn = ldFlush || stFlush;
    strobe.ldWrite = ldValid && (outcome == SRC_CACHE || outcome == SRC_FWD) &&
                     !(strobe.flushEn && !isOlder(ldAge, flushAge));
    strobe.stWrite = stValid && !(strobe.flushEn && !isOlder(stAge, flushAge));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldDone      <= 1'b0;
      ldSource    <= SRC_CACHE;
      ldData      <= '0;
      ldReject    <= 1'b0;
      flushReq    <= 1'b0;
      flushReqAge <= '0;
    end else begin
      ldDone      <= ldValid;
      ldSource    <= ldValid ? outcome : SRC_CACHE;
      ldData      <= (ldValid && outcome == SRC_FWD) ? ldFwdData : '0;
      ldReject    <= ldValid && outcome == SRC_REJECT;
      flushReq    <= strobe.flushEn;
      flushReqAge <= flushAge;
    end
  end

  // R2
  ld_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldDone |-> $past(ldValid));
  // R6
  partial_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldDone && ldSource == SRC_FLUSH |-> flushReq);
  // R5
  reject_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldReject |-> ldDone && ldSource == SRC_REJECT && !$past(stValid));
  // R7
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> $past(ldValid || stValid));

endmodule

// File: rtl/lsq_order_guard.sv
module lsq_order_guard
  import lsq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AGE_W  = 5,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [1:0]        ldSize,
  input  logic [AGE_W-1:0]  ldAge,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic [AGE_W-1:0]  stAge,
  input  logic              stHasData,
  input  logic [63:0]       stData,
  input  logic              sdValid,
  input  logic [AGE_W-1:0]  sdAge,
  input  logic [63:0]       sdData,
  input  logic              stRetValid,
  input  logic [AGE_W-1:0]  stRetAge,
  input  logic              ldRetValid,
  input  logic [AGE_W-1:0]  ldRetAge,
  output logic              ldDone,
  output logic [1:0]        ldSource,
  output logic [63:0]       ldData,
  output logic              ldReject,
  output logic              flushReq,
  output logic [AGE_W-1:0]  flushAge
);

  ctlStrobe_t       strobe;
  logic [AGE_W-1:0] curFlushAge, stViolAge;
  logic             ldHit, ldHitData, ldContained, stViol;
  logic [63:0]      ldFwdData;
  ldSrc_e           srcEnum;

  lsq_datapath #(.DEPTH(DEPTH), .AGE_W(AGE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flushAge(curFlushAge),
    .ldAddr(ldAddr), .ldSize(ldSize), .ldAge(ldAge),
    .stAddr(stAddr), .stSize(stSize), .stAge(stAge),
    .stHasData(stHasData), .stData(stData),
    .sdValid(sdValid), .sdAge(sdAge), .sdData(sdData),
    .stRetValid(stRetValid), .stRetAge(stRetAge),
    .ldRetValid(ldRetValid), .ldRetAge(ldRetAge),
    .ldHit(ldHit), .ldHitData(ldHitData), .ldContained(ldContained),
    .ldFwdData(ldFwdData), .stViol(stViol), .stViolAge(stViolAge)
  );

  lsq_control #(.AGE_W(AGE_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldAge(ldAge), .stValid(stValid), .stAge(stAge),
    .ldHit(ldHit), .ldHitData(ldHitData), .ldContained(ldContained),
    .ldFwdData(ldFwdData), .stViol(stViol), .stViolAge(stViolAge),
    .strobe(strobe), .flushAge(curFlushAge),
    .ldDone(ldDone), .ldSource(srcEnum), .ldData(ldData),
    .ldReject(ldReject), .flushReq(flushReq), .flushReqAge(flushAge)
  );

  assign ldSource = srcEnum;

endmodule

// File: tb/lsq_order_guard_bench.sv
module lsq_order_guard_bench;

  localparam int AGE_W = 5;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldValid = 1'b0, stValid = 1'b0, stHasData = 1'b0, sdValid = 1'b0;
  logic        stRetValid = 1'b0, ldRetValid = 1'b0;
  logic [31:0] ldAddr = '0, stAddr = '0;
  logic [1:0]  ldSize = '0, stSize = '0;
  logic [4:0]  ldAge = '0, stAge = '0, sdAge = '0, stRetAge = '0, ldRetAge = '0;
  logic [63:0] stData = '0, sdData = '0;
  logic        ldDone, ldReject, flushReq;
  logic [1:0]  ldSource;
  logic [63:0] ldData;
  logic [4:0]  flushAge;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lsq_order_guard u_lsq_order_guard (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldAddr(ldAddr), .ldSize(ldSize), .ldAge(ldAge),
    .stValid(stValid), .stAddr(stAddr), .stSize(stSize), .stAge(stAge),
    .stHasData(stHasData), .stData(stData),
    .sdValid(sdValid), .sdAge(sdAge), .sdData(sdData),
    .stRetValid(stRetValid), .stRetAge(stRetAge),
    .ldRetValid(ldRetValid), .ldRetAge(ldRetAge),
    .ldDone(ldDone), .ldSource(ldSource), .ldData(ldData),
    .ldReject(ldReject), .flushReq(flushReq), .flushAge(flushAge)
  );

  // reference model
  logic        mStV[DEPTH], mStHas[DEPTH], mLdV[DEPTH];
  logic [4:0]  mStAge[DEPTH], mLdAge[DEPTH];
  logic [28:0] mStLine[DEPTH], mLdLine[DEPTH];
  logic [7:0]  mStMask[DEPTH], mLdMask[DEPTH];
  logic [2:0]  mStOff[DEPTH];
  logic [63:0] mStWord[DEPTH];

  function automatic bit older(logic [4:0] a, logic [4:0] b);
    logic [4:0] d;
    d = a - b;
    return d[4];
  endfunction

  function automatic logic [7:0] mk(logic [2:0] off, logic [1:0] sz);
    logic [7:0] m;
    m = (sz == 0) ? 8'h01 : (sz == 1) ? 8'h03 : (sz == 2) ? 8'h0F : 8'hFF;
    return m << off;
  endfunction

  function automatic logic [63:0] keepBits(logic [1:0] sz);
    return (sz == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * (1 << sz))) - 64'd1);
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic modelFlush(logic [4:0] f);
    for (int i = 0; i < DEPTH; i++) begin
      if (!older(mStAge[i], f)) mStV[i] = 0;
      if (!older(mLdAge[i], f)) mLdV[i] = 0;
    end
  endtask

  task automatic modelClear();
    for (int i = 0; i < DEPTH; i++) begin
      mStV[i] = 0; mLdV[i] = 0; mStHas[i] = 0;
      mStAge[i] = 0; mLdAge[i] = 0; mStLine[i] = 0; mLdLine[i] = 0;
      mStMask[i] = 0; mLdMask[i] = 0; mStOff[i] = 0; mStWord[i] = 0;
    end
  endtask

  task automatic doLoad(logic [4:0] age, logic [31:0] addr, logic [1:0] sz,
                        output logic [1:0] src, output logic [63:0] dat);
    bit hit; int bi; logic [7:0] m; logic [1:0] es; logic [63:0] ed; string tag;
    hit = 0; bi = 0; m = mk(addr[2:0], sz);
    for (int i = 0; i < DEPTH; i++)
      if (mStV[i] && mStLine[i] == addr[31:3] && (mStMask[i] & m) != 0 &&
          older(mStAge[i], age) && (!hit || older(mStAge[bi], mStAge[i]))) begin
        hit = 1; bi = i;
      end
    ed = '0;
    if (!hit) es = 2'd0;
    else if (!mStHas[bi]) es = 2'd2;
    else if ((m & ~mStMask[bi]) == 0) begin
      es = 2'd1; ed = (mStWord[bi] >> (8 * addr[2:0])) & keepBits(sz);
    end else es = 2'd3;
    tag = (es == 0) ? "R2" : (es == 1) ? "R3" : (es == 2) ? "R5" : "R6";
    ldValid = 1; ldAddr = addr; ldSize = sz; ldAge = age;
    @(negedge clk);
    ldValid = 0;
    check(tag, "ldDone", ldDone, 1);
    check(tag, "ldSource", ldSource, es);
    check(tag, "ldData", ldData, ed);
    check(tag, "ldReject", ldReject, es == 2);
    check(tag, "flushReq", flushReq, es == 3);
    if (es == 3) check("R6", "flushAge", flushAge, age);
    if (es == 0 || es == 1) begin
      for (int i = 0; i < DEPTH; i++)
        if (!mLdV[i]) begin
          mLdV[i] = 1; mLdAge[i] = age; mLdLine[i] = addr[31:3]; mLdMask[i] = m;
          break;
        end
    end else if (es == 3) modelFlush(age);
    src = es; dat = ldData;
  endtask

  task automatic doStore(logic [4:0] age, logic [31:0] addr, logic [1:0] sz, bit has,
                         logic [63:0] d, output bit fl, output logic [4:0] fa);
    bit v; int oi; logic [7:0] m;
    v = 0; oi = 0; m = mk(addr[2:0], sz);
    for (int i = 0; i < DEPTH; i++)
      if (mLdV[i] && mLdLine[i] == addr[31:3] && (mLdMask[i] & m) != 0 &&
          older(age, mLdAge[i]) && (!v || older(mLdAge[i], mLdAge[oi]))) begin
        v = 1; oi = i;
      end
    stValid = 1; stAddr = addr; stSize = sz; stAge = age; stHasData = has; stData = d;
    @(negedge clk);
    stValid = 0;
    check("R7", "flushReq", flushReq, v);
    check("R7", "ldDone", ldDone, 0);
    if (v) check("R7", "flushAge", flushAge, mLdAge[oi]);
    fl = v; fa = v ? mLdAge[oi] : 5'd0;
    if (v) modelFlush(fa);
    for (int i = 0; i < DEPTH; i++)
      if (!mStV[i]) begin
        mStV[i] = 1; mStHas[i] = has; mStAge[i] = age; mStLine[i] = addr[31:3];
        mStMask[i] = m; mStOff[i] = addr[2:0]; mStWord[i] = d << (8 * addr[2:0]);
        break;
      end
  endtask

  task automatic doSd(logic [4:0] age, logic [63:0] d);
    sdValid = 1; sdAge = age; sdData = d;
    @(negedge clk);
    sdValid = 0;
    for (int i = 0; i < DEPTH; i++)
      if (mStV[i] && mStAge[i] == age) begin
        mStHas[i] = 1; mStWord[i] = d << (8 * mStOff[i]);
      end
  endtask

  task automatic retSt(logic [4:0] age);
    stRetValid = 1; stRetAge = age;
    @(negedge clk);
    stRetValid = 0;
    for (int i = 0; i < DEPTH; i++) if (mStV[i] && mStAge[i] == age) mStV[i] = 0;
  endtask

  task automatic retLd(logic [4:0] age);
    ldRetValid = 1; ldRetAge = age;
    @(negedge clk);
    ldRetValid = 0;
    for (int i = 0; i < DEPTH; i++) if (mLdV[i] && mLdAge[i] == age) mLdV[i] = 0;
  endtask

  task automatic drainAll();
    for (int i = 0; i < DEPTH; i++) begin
      if (mStV[i]) retSt(mStAge[i]);
      if (mLdV[i]) retLd(mLdAge[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [1:0]  src;
    logic [63:0] dat;
    bit          fl;
    logic [4:0]  fa;
    logic [4:0]  base;
    void'($urandom(32'd2024));
    modelClear();
    repeat (3) @(negedge clk);
    check("R1", "ldDone", ldDone, 0);
    check("R1", "flushReq", flushReq, 0);
    check("R1", "ldReject", ldReject, 0);
    rstN = 1;
    @(negedge clk);
    doLoad(5'd28, 32'h1000, 2'd3, src, dat);
    check("R1", "first load to cache", src, 0);
    retLd(5'd28);

    // forward with offset, across the age wrap
    doStore(5'd30, 32'h1000, 2'd3, 1, 64'h8877665544332211, fl, fa);
    doLoad(5'd31, 32'h1002, 2'd1, src, dat);
    check("R3", "halfword forward", dat, 64'h4433);
    doStore(5'd0, 32'h1004, 2'd2, 1, 64'hAABBCCDD, fl, fa);
    doLoad(5'd1, 32'h1004, 2'd0, src, dat);
    check("R4", "youngest store wins", dat, 64'hDD);
    check("R9", "wrap ordering source", src, 1);
    doLoad(5'd2, 32'h1000, 2'd0, src, dat);
    check("R4", "other bytes from older store", dat, 64'h11);
    doLoad(5'd29, 32'h1000, 2'd3, src, dat);
    check("R12", "younger stores ignored", src, 0);
    // reject, then late data enables forward
    doStore(5'd3, 32'h1008, 2'd3, 0, 64'h0, fl, fa);
    doLoad(5'd4, 32'h100C, 2'd2, src, dat);
    check("R5", "no data reject", src, 2);
    doSd(5'd3, 64'h0123456789ABCDEF);
    doLoad(5'd4, 32'h100C, 2'd2, src, dat);
    check("R10", "late data forward", dat, 64'h01234567);
    drainAll();
    // partial overlap
    doStore(5'd6, 32'h1010, 2'd1, 1, 64'h5A5A, fl, fa);
    doLoad(5'd7, 32'h1010, 2'd2, src, dat);
    check("R6", "partial overlap flush", src, 3);
    // store finds younger loads
    doLoad(5'd10, 32'h1018, 2'd2, src, dat);
    doLoad(5'd12, 32'h101C, 2'd0, src, dat);
    doStore(5'd9, 32'h1018, 2'd3, 1, 64'h1, fl, fa);
    check("R7", "oldest younger load", fa, 5'd10);
    doStore(5'd8, 32'h101C, 2'd0, 1, 64'h2, fl, fa);
    check("R8", "purged load no flush", fl, 0);
    // retired store stops forwarding
    doStore(5'd13, 32'h1020, 2'd3, 1, 64'h77, fl, fa);
    retSt(5'd13);
    doLoad(5'd14, 32'h1020, 2'd0, src, dat);
    check("R11", "retired store", src, 0);
    drainAll();

    // constrained random episodes
    base = 5'd16;
    for (int ep = 0; ep < 400; ep++) begin
      bit          isSt[6], has[6], gone[6];
      logic [31:0] ad[6];
      logic [1:0]  sz[6];
      logic [63:0] dv[6];
      int          perm[6];
      for (int k = 0; k < 6; k++) begin
        logic [2:0] off;
        isSt[k] = $urandom_range(0, 1) == 1;
        has[k] = $urandom_range(0, 3) != 0;
        gone[k] = 0;
        sz[k] = 2'($urandom_range(0, 3));
        off = 3'($urandom_range(0, 7)) & ~3'((1 << sz[k]) - 1);
        ad[k] = 32'h2000 | (32'($urandom_range(0, 1)) << 3) | 32'(off);
        dv[k] = {$urandom, $urandom};
        perm[k] = k;
      end
      for (int k = 5; k > 0; k--) begin
        int j; int t;
        j = $urandom_range(0, k);
        t = perm[k]; perm[k] = perm[j]; perm[j] = t;
      end
      for (int n = 0; n < 6; n++) begin
        int k;
        logic [4:0] a;
        k = perm[n];
        a = base + 5'(k);
        if (gone[k]) continue;
        fl = 0; fa = 0;
        if (isSt[k]) doStore(a, ad[k], sz[k], has[k], dv[k], fl, fa);
        else begin
          doLoad(a, ad[k], sz[k], src, dat);
          fl = (src == 3); fa = a;
        end
        if (fl)
          for (int q = 0; q < 6; q++)
            if (!older(base + 5'(q), fa)) gone[q] = 1;
      end
      for (int i = 0; i < DEPTH; i++)
        if (mStV[i] && !mStHas[i]) doSd(mStAge[i], {$urandom, $urandom});
      drainAll();
      base = base + 5'd6;
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule